// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a single-data-rate SDRAM and takes the memory from power-on to a state where it can accept normal traffic. After reset it holds the clock enable and the data mask high and keeps a no-operation code on the command pins. It does this for a stabilization interval computed from the clock frequency and a time in microseconds. It then precharges every bank and issues a configurable number of auto-refresh commands. It also programs the mode register from four configuration inputs: burst length, burst ordering, CAS latency and single-write mode. A build parameter decides whether the refresh group or the mode-register load comes first.

Between commands the sequencer drives no-operation for minimum gaps given as cycle counts: precharge to next command, refresh to next command, and mode load to next command. A mode-word builder checks the requested settings before the load command goes out. If the settings form a reserved encoding, no load command is issued. The block raises an error flag and stays in that state until the next reset. When every step has completed, `init_done` rises and stays high, and the bus is left idle for the main controller to take over.

There is no streaming data path. All pins are plain control and status signals. The configuration inputs must stay stable from reset release until `init_done` or `init_err` rises.

Top module: `sdram_boot_seq`

## Requirements
- R1: From reset release, for at least CLK_MHZ*STABLE_US cycles and until `init_done` rises, `sd_cke` and `sd_dqm` stay 1 and the command pins {cs_n,ras_n,cas_n,we_n} show NOP = 0111; during reset `init_done` and `init_err` are 0.
- R2: The first non-NOP command is precharge-all: command 0010, with `sd_addr[10]` = 1 and `sd_ba` = 0.
- R3: Exactly AR_COUNT (at least 2) auto-refresh commands (command 0001) are issued back to back within the refresh group.
- R4: With REFRESH_FIRST = 1 the order is precharge, refresh group, mode load; with REFRESH_FIRST = 0 it is precharge, mode load, refresh group.
- R5: The next command follows a precharge by exactly T_RP cycles, a refresh by exactly T_RC cycles, and a mode load by exactly T_MRD cycles, with NOP on every cycle in between.
- R6: The mode-load command (0000) carries `sd_ba` = 0 and the following address fields: burst-length code on bits 2..0, burst type on bit 3 (1 = interleaved), CAS-latency code on bits 6..4, bits 8..7 = 00, single-write flag on bit 9, and 0 on bit 10 and above.
- R7: The legal settings are burst-length codes 000, 001, 010 and 011, code 111 only with sequential ordering, and CAS-latency codes 010 and 011. Any other setting issues no mode load. Instead `init_err` rises in the cycle the load would have issued, and it stays high.
- R8: `init_done` rises exactly one gap (T_RC or T_MRD) after the last command and stays high. While it is high, the command pins show NOP and `sd_cke` is 1.
- R9: `init_done` and `init_err` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bl_code | input | 3 | Burst-length code |
| cfg_interleave | input | 1 | Burst ordering, 1 = interleaved |
| cfg_cas_code | input | 3 | CAS-latency code |
| cfg_single_write | input | 1 | 1 = single-word write bursts |
| sd_cke | output | 1 | Clock enable to the memory |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_dqm | output | 1 | Data mask |
| sd_ba | output | BA_W | Bank address |
| sd_addr | output | ADDR_W | Row/column address bus |
| init_done | output | 1 | Sequence complete, held high |
| init_err | output | 1 | Reserved mode setting rejected, held high |

## Verification
The rejection of a reserved mode setting falls in the same cycle as the gap expiry that would otherwise launch the mode load. The error flag must take the place of the command exactly on that edge. The bench provokes this with directed and random illegal settings on two instances built with opposite step orders. One instance reaches the rejection just after its precharge; the other reaches it after its full refresh group. A run passes only if no mode-load command appears and `init_err` rises exactly T_RP or T_RC cycles after the last command, as the order dictates.

// File: rtl/sdram_boot_pkg.sv
package sdram_boot_pkg;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sd_cmd_t;

  localparam sd_cmd_t CMD_NOP = sd_cmd_t'(4'b0111);
  localparam sd_cmd_t CMD_PRE = sd_cmd_t'(4'b0010);
  localparam sd_cmd_t CMD_REF = sd_cmd_t'(4'b0001);
  localparam sd_cmd_t CMD_MRS = sd_cmd_t'(4'b0000);

  typedef enum logic [2:0] {
    PH_STABLE,
    PH_REF,
    PH_MODE,
    PH_FINAL,
    PH_READY,
    PH_FAULT
  } boot_phase_t;

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/boot_mode_word.sv
module boot_mode_word #(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [2:0]        bl_code,
  input  logic              interleave,
  input  logic [2:0]        cas_code,
  input  logic              single_write,
  output logic [ADDR_W-1:0] word,
  output logic              legal
);
  logic len_ok;
  logic lat_ok;

  always_comb begin
    word      = '0;
    word[2:0] = bl_code;
    word[3]   = interleave;
    word[6:4] = cas_code;
    word[8:7] = 2'b00;
    word[9]   = single_write;
  end

  // Fixed lengths 1..8 always; full page only with sequential order.
  assign len_ok = (bl_code[2] == 1'b0) || ((bl_code == 3'b111) && !interleave);
  assign lat_ok = (cas_code == 3'b010) || (cas_code == 3'b011);
  assign legal  = len_ok && lat_ok;
endmodule

// File: rtl/boot_gap_timer.sv
module boot_gap_timer #(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned INIT_VAL = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= CNT_W'(INIT_VAL);
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - CNT_W'(1);
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq
  import sdram_boot_pkg::*;
#(
  parameter int unsigned CLK_MHZ       = 200,
  parameter int unsigned STABLE_US     = 200,
  parameter int unsigned AR_COUNT      = 2,
  parameter bit          REFRESH_FIRST = 1'b1,
  parameter int unsigned T_RP          = 3,
  parameter int unsigned T_RC          = 9,
  parameter int unsigned T_MRD         = 2,
  parameter int unsigned ADDR_W        = 12,
  parameter int unsigned BA_W          = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_bl_code,
  input  logic              cfg_interleave,
  input  logic [2:0]        cfg_cas_code,
  input  logic              cfg_single_write,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic              sd_dqm,
  output logic [BA_W-1:0]   sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic              init_done,
  output logic              init_err
);
  localparam int unsigned STABLE_CYC = CLK_MHZ * STABLE_US;
  localparam int unsigned REF_N  = (AR_COUNT < 2) ? 2 : AR_COUNT;
  localparam int unsigned RP_N   = (T_RP  < 1) ? 1 : T_RP;
  localparam int unsigned RC_N   = (T_RC  < 1) ? 1 : T_RC;
  localparam int unsigned MRD_N  = (T_MRD < 1) ? 1 : T_MRD;
  localparam int unsigned LONGEST = max_of(max_of(STABLE_CYC, RP_N), max_of(RC_N, MRD_N));
  localparam int unsigned CNT_W  = $clog2(LONGEST + 1);
  localparam int unsigned REF_W  = $clog2(REF_N + 1);
  localparam int unsigned AP_BIT = 10;

  boot_phase_t       phase_q, phase_d;
  logic [REF_W-1:0]  refs_left_q, refs_left_d;
  sd_cmd_t           cmd_q, cmd_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic              gap_over;
  logic              gap_load;
  logic [CNT_W-1:0]  gap_val;
  logic [ADDR_W-1:0] mode_word;
  logic              mode_legal;

  boot_mode_word #(.ADDR_W(ADDR_W)) u_word (
    .bl_code      (cfg_bl_code),
    .interleave   (cfg_interleave),
    .cas_code     (cfg_cas_code),
    .single_write (cfg_single_write),
    .word         (mode_word),
    .legal        (mode_legal)
  );

  // One shared counter covers the stabilization wait and every command gap.
  boot_gap_timer #(.CNT_W(CNT_W), .INIT_VAL(STABLE_CYC)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (gap_load),
    .load_val (gap_val),
    .expired  (gap_over)
  );

  always_comb begin
    phase_d     = phase_q;
    refs_left_d = refs_left_q;
    cmd_d       = CMD_NOP;
    addr_d      = '0;
    done_d      = done_q;
    err_d       = err_q;
    gap_load    = 1'b0;
    gap_val     = '0;
    case (phase_q)
      PH_STABLE: if (gap_over) begin
        cmd_d          = CMD_PRE;
        addr_d[AP_BIT] = 1'b1;
        gap_load       = 1'b1;
        gap_val        = CNT_W'(RP_N - 1);
        phase_d        = REFRESH_FIRST ? PH_REF : PH_MODE;
      end
      PH_REF: if (gap_over) begin
        cmd_d       = CMD_REF;
        gap_load    = 1'b1;
        gap_val     = CNT_W'(RC_N - 1);
        refs_left_d = refs_left_q - REF_W'(1);
        if (refs_left_q == REF_W'(1))
          phase_d = REFRESH_FIRST ? PH_MODE : PH_FINAL;
      end
      PH_MODE: if (gap_over) begin
        if (mode_legal) begin
          cmd_d    = CMD_MRS;
          addr_d   = mode_word;
          gap_load = 1'b1;
          gap_val  = CNT_W'(MRD_N - 1);
          phase_d  = REFRESH_FIRST ? PH_FINAL : PH_REF;
        end else begin
          err_d   = 1'b1;
          phase_d = PH_FAULT;
        end
      end
      PH_FINAL: if (gap_over) begin
        done_d  = 1'b1;
        phase_d = PH_READY;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_STABLE;
      refs_left_q <= REF_W'(REF_N);
      cmd_q       <= CMD_NOP;
      addr_q      <= '0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      phase_q     <= phase_d;
      refs_left_q <= refs_left_d;
      cmd_q       <= cmd_d;
      addr_q      <= addr_d;
      done_q      <= done_d;
      err_q       <= err_d;
    end
  end

  assign sd_cke    = 1'b1;
  assign sd_dqm    = 1'b1;
  assign sd_cs_n   = cmd_q.cs_n;
  assign sd_ras_n  = cmd_q.ras_n;
  assign sd_cas_n  = cmd_q.cas_n;
  assign sd_we_n   = cmd_q.we_n;
  assign sd_ba     = '0;
  assign sd_addr   = addr_q;
  assign init_done = done_q;
  assign init_err  = err_q;
endmodule

// File: rtl/sdram_boot_seq_chk.sv
module sdram_boot_seq_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned BA_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sd_cke,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic              sd_dqm,
  input logic [BA_W-1:0]   sd_ba,
  input logic [ADDR_W-1:0] sd_addr,
  input logic              init_done,
  input logic              init_err
);
  logic [3:0] pins;
  assign pins = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_err |=> init_err);

  // R9
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(init_done && init_err));

  // R8
  idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (pins == 4'b0111) && sd_cke);

  // R1
  hold_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> sd_cke && sd_dqm);

  // R2
  precharge_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == 4'b0010) |-> sd_addr[10] && (sd_ba == '0));

  // R6
  mode_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == 4'b0000) |-> (sd_ba == '0) && (sd_addr[8:7] == 2'b00) && ((sd_addr >> 10) == '0));

  // R7
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == 4'b0000) |-> ((sd_addr[6:4] == 3'b010) || (sd_addr[6:4] == 3'b011))
      && (!sd_addr[2] || ((sd_addr[2:0] == 3'b111) && !sd_addr[3])));
endmodule

bind sdram_boot_seq sdram_boot_seq_chk #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sd_cke    (sd_cke),
  .sd_cs_n   (sd_cs_n),
  .sd_ras_n  (sd_ras_n),
  .sd_cas_n  (sd_cas_n),
  .sd_we_n   (sd_we_n),
  .sd_dqm    (sd_dqm),
  .sd_ba     (sd_ba),
  .sd_addr   (sd_addr),
  .init_done (init_done),
  .init_err  (init_err)
);

// File: tb/sdram_boot_seq_test.sv
`timescale 1ns/1ps
module sdram_boot_seq_test;
  localparam int CLK_MHZ = 200;
  localparam int STAB_US = 1;
  localparam int NREF    = 3;
  localparam int RP      = 3;
  localparam int RC      = 7;
  localparam int MRD     = 2;
  localparam int AW      = 12;
  localparam int BW      = 2;
  localparam int STABLE  = CLK_MHZ * STAB_US;

  localparam int K_NOP = 0, K_PRE = 1, K_REF = 2, K_MRS = 3, K_BAD = 9;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic [2:0] bl = 3'b011, cas = 3'b010;
  logic       bt = 1'b0, sw = 1'b0;

  logic [1:0] cke, csn, rasn, casn, wen, dqm, done, err;
  logic [BW-1:0] ba [2];
  logic [AW-1:0] addr [2];

  sdram_boot_seq #(.CLK_MHZ(CLK_MHZ), .STABLE_US(STAB_US), .AR_COUNT(NREF), .REFRESH_FIRST(1'b1),
    .T_RP(RP), .T_RC(RC), .T_MRD(MRD), .ADDR_W(AW), .BA_W(BW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_bl_code(bl), .cfg_interleave(bt), .cfg_cas_code(cas),
    .cfg_single_write(sw), .sd_cke(cke[0]), .sd_cs_n(csn[0]), .sd_ras_n(rasn[0]),
    .sd_cas_n(casn[0]), .sd_we_n(wen[0]), .sd_dqm(dqm[0]), .sd_ba(ba[0]), .sd_addr(addr[0]),
    .init_done(done[0]), .init_err(err[0]));

  sdram_boot_seq #(.CLK_MHZ(CLK_MHZ), .STABLE_US(STAB_US), .AR_COUNT(NREF), .REFRESH_FIRST(1'b0),
    .T_RP(RP), .T_RC(RC), .T_MRD(MRD), .ADDR_W(AW), .BA_W(BW)) uut_mf (
    .clk(clk), .rst_n(rst_n), .cfg_bl_code(bl), .cfg_interleave(bt), .cfg_cas_code(cas),
    .cfg_single_write(sw), .sd_cke(cke[1]), .sd_cs_n(csn[1]), .sd_ras_n(rasn[1]),
    .sd_cas_n(casn[1]), .sd_we_n(wen[1]), .sd_dqm(dqm[1]), .sd_ba(ba[1]), .sd_addr(addr[1]),
    .init_done(done[1]), .init_err(err[1]));

  int checks = 0;
  int errors = 0;
  bit closed = 1'b0;

  int k [2];
  int last_cyc [2];
  int last_kind [2];
  bit fin [2];
  bit hold_bad [2];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit is_legal(input logic [2:0] b, input logic t, input logic [2:0] c);
    bit lok = (b == 3'd0) || (b == 3'd1) || (b == 3'd2) || (b == 3'd3) || ((b == 3'd7) && !t);
    bit cok = (c == 3'd2) || (c == 3'd3);
    return lok && cok;
  endfunction

  function automatic logic [AW-1:0] exp_word(input logic [2:0] b, input logic t,
                                             input logic [2:0] c, input logic s);
    logic [AW-1:0] w = '0;
    w[9] = s; w[6:4] = c; w[3] = t; w[2:0] = b;
    return w;
  endfunction

  function automatic int exp_kind(input int inst, input int idx);
    if (idx == 0) return K_PRE;
    if (inst == 0) begin
      if (idx <= NREF) return K_REF;
      if (idx == NREF + 1) return K_MRS;
    end else begin
      if (idx == 1) return K_MRS;
      if (idx <= NREF + 1) return K_REF;
    end
    return K_BAD;
  endfunction

  function automatic int gap_of(input int kind);
    if (kind == K_PRE) return RP;
    if (kind == K_REF) return RC;
    return MRD;
  endfunction

  function automatic int kind_of(input int inst);
    logic [3:0] p = {csn[inst], rasn[inst], casn[inst], wen[inst]};
    case (p)
      4'b0111: return K_NOP;
      4'b0010: return K_PRE;
      4'b0001: return K_REF;
      4'b0000: return K_MRS;
      default: return K_BAD;
    endcase
  endfunction

  task automatic observe(input int inst, input int cyc);
    int kd = kind_of(inst);
    bit lg = is_legal(bl, bt, cas);
    if (fin[inst]) return;
    if (!(cke[inst] && dqm[inst])) hold_bad[inst] = 1'b1;
    if (kd != K_NOP) begin
      // R3 R4: command order and refresh count
      chk(kd == exp_kind(inst, k[inst]), "R4", "command kind", kd, exp_kind(inst, k[inst]));
      if (k[inst] == 0) begin
        chk(cyc >= STABLE, "R1", "first command cycle", cyc, STABLE);
        chk(addr[inst][10] == 1'b1 && ba[inst] == '0, "R2", "precharge A10/bank", int'(addr[inst][10]), 1);
      end else begin
        chk(cyc - last_cyc[inst] == gap_of(last_kind[inst]), "R5", "command spacing",
            cyc - last_cyc[inst], gap_of(last_kind[inst]));
      end
      if (kd == K_MRS) begin
        chk(addr[inst] == exp_word(bl, bt, cas, sw) && ba[inst] == '0, "R6", "mode word",
            int'(addr[inst]), int'(exp_word(bl, bt, cas, sw)));
        chk(lg, "R7", "mode load with legal settings", 0, 1);
      end
      k[inst]++;
      last_cyc[inst] = cyc;
      last_kind[inst] = kd;
    end
    if (done[inst]) begin
      fin[inst] = 1'b1;
      chk(lg, "R7", "done only for legal settings", 1, int'(lg));
      chk(k[inst] == NREF + 2, "R3", "commands before done", k[inst], NREF + 2);
      chk(cyc - last_cyc[inst] == gap_of(last_kind[inst]), "R8", "done delay",
          cyc - last_cyc[inst], gap_of(last_kind[inst]));
    end else if (err[inst]) begin
      fin[inst] = 1'b1;
      chk(!lg, "R7", "error only for reserved settings", 1, int'(!lg));
      chk(k[inst] == ((inst == 0) ? NREF + 1 : 1), "R7", "commands before error",
          k[inst], (inst == 0) ? NREF + 1 : 1);
      chk(cyc - last_cyc[inst] == gap_of(last_kind[inst]), "R7", "error slot",
          cyc - last_cyc[inst], gap_of(last_kind[inst]));
    end
  endtask

  task automatic run_trial(input logic [2:0] b, input logic t, input logic [2:0] c, input logic s);
    int cyc = 0;
    bit lg = is_legal(b, t, c);
    bl = b; bt = t; cas = c; sw = s;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      // R1: reset state
      chk(done[i] == 1'b0 && err[i] == 1'b0, "R1", "flags in reset", int'({done[i], err[i]}), 0);
      chk(kind_of(i) == K_NOP && cke[i] && dqm[i], "R1", "pins in reset", kind_of(i), K_NOP);
      k[i] = 0; last_cyc[i] = 0; last_kind[i] = K_NOP; fin[i] = 1'b0; hold_bad[i] = 1'b0;
    end
    rst_n = 1'b1;
    while (cyc < STABLE + 200 && !(fin[0] && fin[1])) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      observe(0, cyc);
      observe(1, cyc);
    end
    for (int i = 0; i < 2; i++) begin
      chk(fin[i], "R7", "sequence terminated", int'(fin[i]), 1);
      chk(!hold_bad[i], "R1", "cke/dqm held high", int'(hold_bad[i]), 0);
      chk(lg ? done[i] : err[i], "R8", "final flag", int'({done[i], err[i]}), lg ? 2 : 1);
    end
    repeat (4) begin
      @(posedge clk);
      @(negedge clk);
      for (int i = 0; i < 2; i++) begin
        chk(done[i] == lg && err[i] == !lg, "R9", "flags stay exclusive and held",
            int'({done[i], err[i]}), lg ? 2 : 1);
        chk(kind_of(i) == K_NOP && cke[i], "R8", "idle bus after end", kind_of(i), K_NOP);
      end
    end
  endtask

  task automatic finish_run();
    if (!closed) begin
      closed = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    run_trial(3'b011, 1'b0, 3'b010, 1'b0);   // burst 8, CL2
    run_trial(3'b111, 1'b0, 3'b011, 1'b1);   // full page sequential, single write
    run_trial(3'b111, 1'b1, 3'b011, 1'b0);   // R7: full page interleaved is reserved
    run_trial(3'b000, 1'b1, 3'b001, 1'b0);   // R7: CL1 reserved
    run_trial(3'b100, 1'b0, 3'b010, 1'b0);   // R7: length code 100 reserved
    run_trial(3'b010, 1'b1, 3'b011, 1'b1);   // burst 4 interleaved
    for (int n = 0; n < 14; n++) begin
      logic [2:0] rb = 3'($urandom % 8);
      logic [2:0] rc = (n % 2 == 0) ? 3'(2 + $urandom % 2) : 3'($urandom % 8);
      run_trial(rb, 1'($urandom % 2), rc, 1'($urandom % 2));
    end
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end
endmodule